// File: doc/BRIEF.md
# Asynchronous Static RAM Sequencer

This block connects a synchronous request port to an external asynchronous static RAM of 32K words by 16 bits. The RAM has separate lower-byte and upper-byte lane selects. A client asks for one read or one write at a time. Each request carries a direction flag, a word address, write data and a two-bit lane mask. The sequencer answers a read with a one-cycle valid strobe and the captured word.

On the memory side the block drives active-low chip enable, output enable, write enable and the two lane selects, and it presents the address. The data bus is split into an outgoing word, an incoming word and a drive-enable. The drive-enable is meant for an I/O cell at the chip edge.

Every access runs as a fixed sequence of phases. Each phase length is a parameter counted in clock cycles, so one design can be tuned to any speed grade at any clock rate. The write strobe is closed while the outgoing data is still driven, which lets the memory latch data on the rising edge of write enable. After a read, the bus is handed back only after output enable has been high for a turnaround gap.

Top module: `sram_ctrl`

## Requirements
- R1: Out of reset, and whenever the block is idle, `req_ready` is 1, `rsp_valid` is 0, `mem_ce_n`, `mem_oe_n`, `mem_we_n`, `mem_lb_n` and `mem_ub_n` are all 1, and `mem_dq_oe` is 0.
- R2: A request is taken on a rising clock edge where `req_valid` and `req_ready` are both 1. From the next cycle `req_ready` stays 0 until the access finishes. Requests presented while `req_ready` is 0 are dropped and leave the memory unchanged.
- R3: A write holds `mem_ce_n` low and `mem_oe_n` high. `mem_we_n` is low for exactly STROBE_CYC cycles, after SETUP_CYC cycles of address and data setup. `mem_dq_oe` is 1 from the first setup cycle through the cycle after `mem_we_n` rises, so the data is valid at that rising edge.
- R4: Lane mask bit 0 enables data bits 7:0 by driving `mem_lb_n` low. Bit 1 enables bits 15:8 by driving `mem_ub_n` low. A write changes only the enabled lanes.
- R5: A read holds `mem_ce_n` low and `mem_we_n` high for SETUP_CYC cycles with `mem_oe_n` high, then for ACCESS_CYC cycles with `mem_oe_n` low. The bus is sampled in the last of those cycles. `rsp_valid` is then high for exactly one cycle, with `rsp_rdata` holding the sampled word and any lane not enabled by the mask forced to zero.
- R6: Counting the cycles where `req_ready` is 0 after an accepting edge: a read is busy for SETUP_CYC+ACCESS_CYC cycles and reports `rsp_valid` in the first ready cycle. A write is busy for SETUP_CYC+STROBE_CYC+1 cycles, plus TURN_CYC more when the previous access was a read.
- R7: `mem_addr` changes only at the edge where a request is accepted. It is stable in every cycle where `mem_ce_n` was already low in the cycle before.
- R8: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. When a write follows a read, TURN_CYC cycles with `mem_oe_n` high and `mem_dq_oe` low come before the write's setup phase.
- R9: A phase-length parameter of 0 behaves as 1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| req_ready | output | 1 | Block idle, request can be taken |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Read data, disabled lanes zero |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_lb_n | output | 1 | Lower lane select, active low |
| mem_ub_n | output | 1 | Upper lane select, active low |
| mem_addr | output | 15 | Memory address |
| mem_dq_o | output | 16 | Data driven toward the memory |
| mem_dq_i | input | 16 | Data returned from the memory |
| mem_dq_oe | output | 1 | Drive-enable for `mem_dq_o` |

## Verification
The assertions assume that the strobes depend only on the block's own state. They also assume that the request inputs are stable whenever they are sampled, and that `req_valid` may stay high while the block is busy. The stimulus changes inputs only a few nanoseconds after a rising edge. It deliberately holds a competing request high during a write to show that the request is dropped. It mixes reads and writes, including write-after-read and read-after-read, with single-lane and full-word masks at the lowest and highest addresses. The behavioural memory in the bench drives its lanes only under the read conditions. It flags any overlap with `mem_dq_oe`, including one extra cycle in which the memory may still be driving the bus.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE    = 3'd0,
    SEQ_TURN    = 3'd1,
    SEQ_WSETUP  = 3'd2,
    SEQ_WSTROBE = 3'd3,
    SEQ_WHOLD   = 3'd4,
    SEQ_RSETUP  = 3'd5,
    SEQ_RACCESS = 3'd6
  } seq_state_e;

  // phase lengths below one cycle are raised to one
  function automatic int unsigned min_one(input int unsigned n);
    return (n == 0) ? 1 : n;
  endfunction

  function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                          input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
`timescale 1ns/1ps
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned SETUP_N  = 1,
  parameter int unsigned STROBE_N = 2,
  parameter int unsigned ACCESS_N = 2,
  parameter int unsigned TURN_N   = 1,
  parameter int unsigned CNT_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             start_write,
  input  logic             phase_last,
  output seq_state_e       state,
  output logic             timer_load,
  output logic [CNT_W-1:0] timer_val,
  output logic             capture
);

  seq_state_e state_q, state_d;
  logic       after_read_q, after_read_d;

  function automatic logic [CNT_W-1:0] phase_len_m1(input seq_state_e s);
    int unsigned len;
    case (s)
      SEQ_TURN:                len = TURN_N;
      SEQ_WSETUP, SEQ_RSETUP:  len = SETUP_N;
      SEQ_WSTROBE:             len = STROBE_N;
      SEQ_RACCESS:             len = ACCESS_N;
      default:                 len = 1;
    endcase
    return CNT_W'(len - 1);
  endfunction

  always_comb begin
    state_d      = state_q;
    after_read_d = after_read_q;
    case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          if (!start_write)     state_d = SEQ_RSETUP;
          else if (after_read_q) state_d = SEQ_TURN;
          else                  state_d = SEQ_WSETUP;
        end
      end
      SEQ_TURN:    if (phase_last) state_d = SEQ_WSETUP;
      SEQ_WSETUP:  if (phase_last) state_d = SEQ_WSTROBE;
      SEQ_WSTROBE: if (phase_last) state_d = SEQ_WHOLD;
      SEQ_WHOLD:                   state_d = SEQ_IDLE;
      SEQ_RSETUP:  if (phase_last) state_d = SEQ_RACCESS;
      SEQ_RACCESS: if (phase_last) state_d = SEQ_IDLE;
      default:                     state_d = SEQ_IDLE;
    endcase
    if (state_q == SEQ_RACCESS && state_d == SEQ_IDLE) after_read_d = 1'b1;
    if (state_d == SEQ_WSETUP)                         after_read_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= SEQ_IDLE;
      after_read_q <= 1'b0;
    end else begin
      state_q      <= state_d;
      after_read_q <= after_read_d;
    end
  end

  assign state      = state_q;
  assign timer_load = (state_d != state_q);
  assign timer_val  = phase_len_m1(state_d);
  assign capture    = (state_q == SEQ_RACCESS) && phase_last;

endmodule

// File: rtl/sram_rd_capture.sv
`timescale 1ns/1ps
module sram_rd_capture #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  logic [DATA_W-1:0] masked;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign masked[g*8 +: 8] = lane_en[g] ? bus_in[g*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture;
      if (capture) rdata_q <= masked;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned SETUP_CYC  = 1,
  parameter int unsigned STROBE_CYC = 2,
  parameter int unsigned ACCESS_CYC = 2,
  parameter int unsigned TURN_CYC   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_be,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_lb_n,
  output logic              mem_ub_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe
);

  localparam int unsigned SETUP_N  = min_one(SETUP_CYC);
  localparam int unsigned STROBE_N = min_one(STROBE_CYC);
  localparam int unsigned ACCESS_N = min_one(ACCESS_CYC);
  localparam int unsigned TURN_N   = min_one(TURN_CYC);
  localparam int unsigned LONGEST  = max_of4(SETUP_N, STROBE_N, ACCESS_N, TURN_N);
  localparam int unsigned CNT_W    = (LONGEST < 2) ? 1 : $clog2(LONGEST);

  seq_state_e        state;
  logic              accept;
  logic              timer_load;
  logic [CNT_W-1:0]  timer_val;
  logic              phase_last;
  logic              capture;

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0]        be_q;
  logic              in_write;
  logic              in_read;

  assign req_ready = (state == SEQ_IDLE);
  assign accept    = req_valid && req_ready;

  // request registers, loaded only on an accepting edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      be_q    <= req_be;
    end
  end

  sram_seq_fsm #(
    .SETUP_N (SETUP_N),
    .STROBE_N(STROBE_N),
    .ACCESS_N(ACCESS_N),
    .TURN_N  (TURN_N),
    .CNT_W   (CNT_W)
  ) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_write(req_write),
    .phase_last (phase_last),
    .state      (state),
    .timer_load (timer_load),
    .timer_val  (timer_val),
    .capture    (capture)
  );

  sram_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (timer_load),
    .load_val(timer_val),
    .last    (phase_last)
  );

  sram_rd_capture #(.DATA_W(DATA_W), .LANES(2)) cap_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .capture(capture),
    .lane_en(be_q),
    .bus_in (mem_dq_i),
    .rdata  (rsp_rdata),
    .rvalid (rsp_valid)
  );

  assign in_write = (state == SEQ_WSETUP) || (state == SEQ_WSTROBE) || (state == SEQ_WHOLD);
  assign in_read  = (state == SEQ_RSETUP) || (state == SEQ_RACCESS);

  assign mem_ce_n  = !(in_write || in_read);
  assign mem_we_n  = (state != SEQ_WSTROBE);
  assign mem_oe_n  = (state != SEQ_RACCESS);
  assign mem_lb_n  = !((in_write || in_read) && be_q[0]);
  assign mem_ub_n  = !((in_write || in_read) && be_q[1]);
  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign mem_dq_oe = in_write;

endmodule

// File: rtl/sram_ctrl_chk.sv
`timescale 1ns/1ps
module sram_ctrl_chk #(
  parameter int unsigned ADDR_W     = 15,
  parameter int unsigned STROBE_CYC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_ce_n,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe
);

  localparam int unsigned STROBE_N = (STROBE_CYC == 0) ? 1 : STROBE_CYC;

  logic [15:0] we_low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        we_low_cnt <= '0;
    else if (!mem_we_n) we_low_cnt <= we_low_cnt + 16'd1;
    else               we_low_cnt <= '0;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_data_held_at_we_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);

  assert_we_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_low_cnt == 16'(STROBE_N)));

  assert_strobes_need_ce_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n || !mem_oe_n) |-> !mem_ce_n);

  assert_oe_we_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_we_n && !mem_oe_n));

  assert_rsp_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  assert_no_contention_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

endmodule

bind sram_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W), .STROBE_CYC(STROBE_CYC)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .mem_ce_n (mem_ce_n),
  .mem_oe_n (mem_oe_n),
  .mem_we_n (mem_we_n),
  .mem_addr (mem_addr),
  .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_ctrl_tb_top.sv
`timescale 1ns/1ps
module sram_ctrl_tb_top;

  // SETUP given as 0 to exercise the one-cycle floor (R9)
  localparam int SU = 1;
  localparam int ST = 2;
  localparam int AC = 2;
  localparam int TU = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [14:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
  logic [14:0] mem_addr;
  logic [15:0] mem_dq_o;
  logic [15:0] mem_dq_i;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  sram_ctrl #(
    .SETUP_CYC(0), .STROBE_CYC(ST), .ACCESS_CYC(AC), .TURN_CYC(TU)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_be(req_be),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n), .mem_addr(mem_addr),
    .mem_dq_o(mem_dq_o), .mem_dq_i(mem_dq_i), .mem_dq_oe(mem_dq_oe)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural memory ----------------
  logic [15:0] mem_arr [int];
  int          wr_evt = 0;

  function automatic logic [15:0] mem_get(input int a);
    return mem_arr.exists(a) ? mem_arr[a] : 16'h0000;
  endfunction

  always @(mem_addr or mem_ce_n or mem_oe_n or mem_we_n or mem_lb_n or mem_ub_n or wr_evt) begin
    logic [15:0] w;
    w = mem_get(int'(mem_addr));
    mem_dq_i[7:0]  = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_lb_n) ? w[7:0]  : 8'hzz;
    mem_dq_i[15:8] = (!mem_ce_n && !mem_oe_n && mem_we_n && !mem_ub_n) ? w[15:8] : 8'hzz;
  end

  // data is latched at the rising edge of write enable (R3, R4)
  always @(posedge mem_we_n) begin
    if (rst_n && !mem_ce_n) begin
      logic [15:0] w;
      check(mem_dq_oe == 1'b1, "R3 data driven at we rise", mem_dq_oe, 1);
      w = mem_get(int'(mem_addr));
      if (!mem_lb_n) w[7:0]  = mem_dq_o[7:0];
      if (!mem_ub_n) w[15:8] = mem_dq_o[15:8];
      mem_arr[int'(mem_addr)] = w;
      wr_evt++;
    end
  end

  // R7: address must not move during a write strobe
  always @(mem_addr) begin
    if (rst_n && !mem_ce_n && !mem_we_n)
      check(1'b0, "R7 address moved under strobe", mem_addr, 0);
  end

  // R3: strobe width in time
  realtime we_fall_t;
  always @(negedge mem_we_n) we_fall_t = $realtime;
  always @(posedge mem_we_n) begin
    if (rst_n && we_fall_t > 0)
      check(($realtime - we_fall_t) == ST * 20.0, "R3 we pulse width",
            32'($rtoi($realtime - we_fall_t)), ST * 20);
  end

  // ---------------- cycle reference model ----------------
  logic [15:0] shadow [int];
  int          busy = 0;
  bit          cur_rd = 1'b0;
  bit          last_rd = 1'b0;
  bit          rsp_due = 1'b0;
  logic [15:0] exp_data = '0;
  bit          mem_drv_prev = 1'b0;
  bit          ref_on = 1'b0;

  function automatic logic [15:0] sh_get(input int a);
    return shadow.exists(a) ? shadow[a] : 16'h0000;
  endfunction

  always @(negedge clk) begin
    if (ref_on) begin
      bit mem_drv;
      check(req_ready == (busy == 0), "R6 ready timing", req_ready, busy == 0);
      check(rsp_valid == rsp_due, "R5 rsp_valid timing", rsp_valid, rsp_due);
      if (rsp_due) check(rsp_rdata == exp_data, "R5 read data", rsp_rdata, exp_data);
      mem_drv = !mem_ce_n && !mem_oe_n && mem_we_n && (!mem_lb_n || !mem_ub_n);
      check(!(mem_dq_oe && (mem_drv || mem_drv_prev)), "R8 bus contention",
            mem_dq_oe, 0);
      if (busy == 0)
        check(mem_ce_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n && !mem_dq_oe,
              "R1 idle strobes", {mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe},
              6'b111110);
      mem_drv_prev = mem_drv;
      rsp_due = 1'b0;
      if (busy == 1 && cur_rd) rsp_due = 1'b1;
      if (busy > 0) busy--;
      else if (req_valid) begin
        cur_rd = !req_write;
        if (req_write) begin
          logic [15:0] w;
          busy = SU + ST + 1 + (last_rd ? TU : 0);
          w = sh_get(int'(req_addr));
          if (req_be[0]) w[7:0]  = req_wdata[7:0];
          if (req_be[1]) w[15:8] = req_wdata[15:8];
          shadow[int'(req_addr)] = w;
          last_rd = 1'b0;
        end else begin
          logic [15:0] w;
          busy = SU + AC;
          w = sh_get(int'(req_addr));
          exp_data = {req_be[1] ? w[15:8] : 8'h00, req_be[0] ? w[7:0] : 8'h00};
          last_rd = 1'b1;
        end
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic issue(input bit wr, input logic [14:0] a, input logic [15:0] d, input logic [1:0] be);
    @(posedge clk); #2;
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!req_ready);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    check(req_ready && !rsp_valid && mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe,
          "R1 reset state", {req_ready, rsp_valid, mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe},
          6'b101110);
    rst_n = 1'b1;
    @(negedge clk);
    ref_on = 1'b1;

    // R3, R6: full word write, R9 with SETUP given as zero
    issue(1'b1, 15'd5, 16'hA5A5, 2'b11);
    // R5: full read
    issue(1'b0, 15'd5, 16'h0000, 2'b11);
    // R4, R8: low-lane write directly after a read (turnaround)
    issue(1'b1, 15'd5, 16'h1234, 2'b01);
    issue(1'b0, 15'd5, 16'h0000, 2'b11);
    // R4: high-lane write
    issue(1'b1, 15'd5, 16'h7CEE, 2'b10);
    // R5: single-lane reads, other lane zero
    issue(1'b0, 15'd5, 16'h0000, 2'b01);
    issue(1'b0, 15'd5, 16'h0000, 2'b10);
    // boundary addresses
    issue(1'b1, 15'h7FFF, 16'hBEEF, 2'b11);
    issue(1'b1, 15'h0000, 16'h0F0F, 2'b11);
    issue(1'b0, 15'h7FFF, 16'h0000, 2'b11);
    issue(1'b0, 15'h0000, 16'h0000, 2'b11);
    wait_idle();

    // R2: competing request held while busy is dropped
    issue(1'b1, 15'd9, 16'h5555, 2'b11);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 15'd9; req_wdata = 16'hDEAD; req_be = 2'b11;
    @(posedge clk); #2;
    @(posedge clk); #2;
    req_valid = 1'b0;
    wait_idle();
    issue(1'b0, 15'd9, 16'h0000, 2'b11);
    // mask of zero writes nothing
    issue(1'b1, 15'd9, 16'hFFFF, 2'b00);
    issue(1'b0, 15'd9, 16'h0000, 2'b11);
    wait_idle();
    repeat (3) @(negedge clk);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

endmodule